// File: doc/BRIEF.md
# Replicated Brick Cache with Two-Section Ping-Pong Banks

This block sits between a memory fetch engine and a set of processing pipelines. The fetch engine drives one shared write bus. A mask register picks the banks that capture each word on that bus, so a single pass over a brick can place identical copies of it in several banks. Each pipeline can then read neighbouring samples from separate copies in the same cycle. Banks are arranged in groups of four, and each group serves one pipeline with four samples per cycle.

Every bank holds two sections, and each section holds one whole brick. The two sections form a FIFO of depth two whose unit of transfer is a complete brick. The fetch side fills one section while the pipeline reads the other through its own port. A brick becomes readable when the write that marks its last word is accepted. It stays readable until the reader releases it, and the roles of the two sections then swap. When both sections of a bank hold bricks that have not been released, that bank refuses new words and raises a busy flag. A read from a bank that has no complete brick returns no valid data, and the pipeline has to stall.

Top module: `brick_cache_bank`

## Requirements
- R1: After reset, all section-full flags, all busy flags, all read-valid flags and the group-ready flags are 0, and every read-data lane is 0. The mask register is 0, so no bank captures a write.
- R2: When mask_load is 1 at a clock edge, mask_in is loaded into the mask register. Bit b of the mask enables bank b. A write only reaches the banks whose mask bit is 1. A write in the same cycle as a mask load uses the mask value from before the load.
- R3: When rd_req[b] is 1 and bank b's read section holds a brick, rd_data lane b shows the word at rd_addr lane b of that section one cycle later. Banks filled from the same broadcast brick return identical words.
- R4: A write that is accepted with wr_last set marks the section being filled as full, and filling moves to the other section. Each bank fills section 0 first and then alternates. The full flag of section s of bank b is sect_full bit 2*b+s.
- R5: While both sections of bank b are full, fill_busy[b] is 1. Bank b then ignores broadcast words: its contents and flags stay unchanged.
- R6: rd_release[b] while bank b's read section is full clears that section's flag and moves reading to the other section. A release while the read section is empty has no effect.
- R7: A read request to a bank whose read section is not full gives rd_valid 0 in the next cycle. rd_data keeps its previous value whenever no valid read occurs.
- R8: grp_ready[g] is 1 exactly when each of banks GROUP_SIZE*g to GROUP_SIZE*g+GROUP_SIZE-1 has a full read section.
- R9: A bank accepts a fill into one section while returning valid reads from its other section in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_load | input | 1 | Load mask_in into the bank mask register |
| mask_in | input | NUM_BANKS | New bank-capture mask |
| wr_valid | input | 1 | Broadcast word present |
| wr_last | input | 1 | Word is the last one of its brick |
| wr_addr | input | ADDR_W | Word offset within the section |
| wr_data | input | DATA_W | Broadcast word |
| rd_req | input | NUM_BANKS | Read request, one per bank |
| rd_release | input | NUM_BANKS | Release the current read section, one per bank |
| rd_addr | input | NUM_BANKS*ADDR_W | Read offset, one lane per bank |
| rd_data | output | NUM_BANKS*DATA_W | Read word, one lane per bank |
| rd_valid | output | NUM_BANKS | rd_data lane holds a word read in the previous cycle |
| sect_full | output | 2*NUM_BANKS | Full flag per section, bit 2*b+s |
| fill_busy | output | NUM_BANKS | Both sections of the bank are full |
| grp_ready | output | NUM_BANKS/GROUP_SIZE | Every bank of the group has a readable brick |

## Verification
The bricks are broadcast under several mask patterns. A zero mask, and a mask loaded in the same cycle as a brick's last word, must leave every bank empty. A sparse mask must fill only alternate banks, and a full mask must fill every bank, which separates capture from refusal. Reads are issued to both filled and empty banks, so valid data can be told apart from a stall, and identical lanes show that the brick was copied correctly. Writes continue after banks report busy, and releases are issued on empty banks; later reads must show old contents and an unchanged read order. One case fills and reads the same bank in the same cycles.

// File: rtl/brick_cache_pkg.sv
package brick_cache_pkg;
  typedef enum logic {SECT_LO = 1'b0, SECT_HI = 1'b1} sect_id_e;

  typedef struct packed {
    logic [1:0] full;
    sect_id_e   fill_sel;
    sect_id_e   read_sel;
  } bank_state_t;

  function automatic sect_id_e other_sect(input sect_id_e s);
    return (s == SECT_LO) ? SECT_HI : SECT_LO;
  endfunction
endpackage

// File: rtl/brick_bank_ctrl.sv
module brick_bank_ctrl
  import brick_cache_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_hit,
  input  logic     wr_last,
  input  logic     rd_req,
  input  logic     rd_release,
  output logic     wr_en,
  output sect_id_e wr_sect,
  output logic     rd_en,
  output sect_id_e rd_sect,
  output logic [1:0] full,
  output logic     busy,
  output logic     rd_ready,
  output logic     rd_valid
);
  bank_state_t st_q, st_d;
  logic        rd_valid_q;
  logic        rel_ok;

  always_comb begin
    wr_en   = wr_hit & ~st_q.full[st_q.fill_sel];
    rd_en   = rd_req & st_q.full[st_q.read_sel];
    rel_ok  = rd_release & st_q.full[st_q.read_sel];
    wr_sect = st_q.fill_sel;
    rd_sect = st_q.read_sel;
  end

  always_comb begin
    st_d = st_q;
    if (wr_en && wr_last) begin
      st_d.full[st_q.fill_sel] = 1'b1;
      st_d.fill_sel            = other_sect(st_q.fill_sel);
    end
    if (rel_ok) begin
      st_d.full[st_q.read_sel] = 1'b0;
      st_d.read_sel            = other_sect(st_q.read_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= '{full: 2'b00, fill_sel: SECT_LO, read_sel: SECT_LO};
      rd_valid_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      rd_valid_q <= rd_en;
    end
  end

  assign full     = st_q.full;
  assign busy     = &st_q.full;
  assign rd_ready = st_q.full[st_q.read_sel];
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/brick_bank_ram.sv
module brick_bank_ram
  import brick_cache_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int SECT_DEPTH = 512,
  localparam int ADDR_W    = $clog2(SECT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sect_id_e          wr_sect,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  sect_id_e          rd_sect,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 2 * SECT_DEPTH;

  logic [DATA_W-1:0] store [WORDS];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[{wr_sect, wr_addr}] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= store[{rd_sect, rd_addr}];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/brick_cache_bank.sv
module brick_cache_bank
  import brick_cache_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int GROUP_SIZE = 4,
  parameter int DATA_W     = 64,
  parameter int SECT_DEPTH = 512,
  localparam int ADDR_W     = $clog2(SECT_DEPTH),
  localparam int NUM_GROUPS = NUM_BANKS / GROUP_SIZE
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mask_load,
  input  logic [NUM_BANKS-1:0]        mask_in,
  input  logic                        wr_valid,
  input  logic                        wr_last,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NUM_BANKS-1:0]        rd_req,
  input  logic [NUM_BANKS-1:0]        rd_release,
  input  logic [NUM_BANKS*ADDR_W-1:0] rd_addr,
  output logic [NUM_BANKS*DATA_W-1:0] rd_data,
  output logic [NUM_BANKS-1:0]        rd_valid,
  output logic [2*NUM_BANKS-1:0]      sect_full,
  output logic [NUM_BANKS-1:0]        fill_busy,
  output logic [NUM_GROUPS-1:0]       grp_ready
);
  logic [NUM_BANKS-1:0] mask_q, mask_d;
  logic [NUM_BANKS-1:0] rd_ready_w;

  always_comb begin
    mask_d = mask_q;
    if (mask_load) mask_d = mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic     wr_en, rd_en;
    sect_id_e wr_sect, rd_sect;

    brick_bank_ctrl ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_valid & mask_q[b]),
      .wr_last   (wr_last),
      .rd_req    (rd_req[b]),
      .rd_release(rd_release[b]),
      .wr_en     (wr_en),
      .wr_sect   (wr_sect),
      .rd_en     (rd_en),
      .rd_sect   (rd_sect),
      .full      (sect_full[2*b +: 2]),
      .busy      (fill_busy[b]),
      .rd_ready  (rd_ready_w[b]),
      .rd_valid  (rd_valid[b])
    );

    brick_bank_ram #(.DATA_W(DATA_W), .SECT_DEPTH(SECT_DEPTH)) ram_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sect(wr_sect),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_en  (rd_en),
      .rd_sect(rd_sect),
      .rd_addr(rd_addr[b*ADDR_W +: ADDR_W]),
      .rd_data(rd_data[b*DATA_W +: DATA_W])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign grp_ready[g] = &rd_ready_w[g*GROUP_SIZE +: GROUP_SIZE];
  end
endmodule

// File: rtl/brick_cache_chk.sv
module brick_cache_chk #(
  parameter int NUM_BANKS  = 4,
  parameter int GROUP_SIZE = 4,
  localparam int NUM_GROUPS = NUM_BANKS / GROUP_SIZE
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_last,
  input logic [NUM_BANKS-1:0]   rd_req,
  input logic [NUM_BANKS-1:0]   rd_release,
  input logic [NUM_BANKS-1:0]   rd_valid,
  input logic [2*NUM_BANKS-1:0] sect_full,
  input logic [NUM_BANKS-1:0]   fill_busy,
  input logic [NUM_GROUPS-1:0]  grp_ready
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    for (genvar s = 0; s < 2; s++) begin : g_s
      a_r4_fill_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sect_full[2*b+s]) |-> $past(wr_valid && wr_last));
      a_r6_clear_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sect_full[2*b+s]) |-> $past(rd_release[b]));
    end
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      fill_busy[b] && !rd_release[b] |=> fill_busy[b]);
    a_r7_valid_needs_brick: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[b] |-> $past(rd_req[b]) && $past(sect_full[2*b] || sect_full[2*b+1]));
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_g
    for (genvar k = 0; k < GROUP_SIZE; k++) begin : g_k
      a_r8_group_has_bricks: assert property (@(posedge clk) disable iff (!rst_n)
        grp_ready[g] |-> (sect_full[2*(g*GROUP_SIZE+k)] || sect_full[2*(g*GROUP_SIZE+k)+1]));
    end
  end
endmodule

bind brick_cache_bank brick_cache_chk #(
  .NUM_BANKS (NUM_BANKS),
  .GROUP_SIZE(GROUP_SIZE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_last   (wr_last),
  .rd_req    (rd_req),
  .rd_release(rd_release),
  .rd_valid  (rd_valid),
  .sect_full (sect_full),
  .fill_busy (fill_busy),
  .grp_ready (grp_ready)
);

// File: tb/brick_cache_bank_tb.sv
module brick_cache_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int GS = 4;
  localparam int NG = NB / GS;
  localparam int DW = 64;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic mask_load;
  logic [NB-1:0] mask_in;
  logic wr_valid, wr_last;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NB-1:0] rd_req, rd_release;
  logic [NB*AW-1:0] rd_addr;
  logic [NB*DW-1:0] rd_data;
  logic [NB-1:0] rd_valid, fill_busy;
  logic [2*NB-1:0] sect_full;
  logic [NG-1:0] grp_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  brick_cache_bank #(.NUM_BANKS(NB), .GROUP_SIZE(GS), .DATA_W(DW), .SECT_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mask_load(mask_load), .mask_in(mask_in),
    .wr_valid(wr_valid), .wr_last(wr_last), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_release(rd_release), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .sect_full(sect_full),
    .fill_busy(fill_busy), .grp_ready(grp_ready)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wd(input int id, input int a);
    return {16'(16'hB0C0 + id), 16'(a), 32'(id * 977 + a)};
  endfunction

  // behavioural reference model
  logic [NB-1:0] m_mask;
  bit            m_full [NB][2];
  int            m_w [NB];
  int            m_r [NB];
  logic [DW-1:0] m_mem [NB][2][DEPTH];
  bit            m_valid [NB];
  logic [DW-1:0] m_data [NB];
  bit wa, ra, rl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0;
      for (int b = 0; b < NB; b++) begin
        m_full[b][0] = 0; m_full[b][1] = 0;
        m_w[b] = 0; m_r[b] = 0; m_valid[b] = 0; m_data[b] = '0;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        wa = wr_valid && m_mask[b] && !m_full[b][m_w[b]];
        ra = rd_req[b] && m_full[b][m_r[b]];
        rl = rd_release[b] && m_full[b][m_r[b]];
        if (ra) m_data[b] = m_mem[b][m_r[b]][rd_addr[b*AW +: AW]];
        m_valid[b] = ra;
        if (wa) m_mem[b][m_w[b]][wr_addr] = wr_data;
        if (wa && wr_last) begin m_full[b][m_w[b]] = 1; m_w[b] = 1 - m_w[b]; end
        if (rl) begin m_full[b][m_r[b]] = 0; m_r[b] = 1 - m_r[b]; end
      end
      if (mask_load) m_mask = mask_in;
    end
  end

  // per-cycle comparison against the model
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      for (int b = 0; b < NB; b++) begin
        chk(fill_busy[b] === (m_full[b][0] && m_full[b][1]), "R5 fill_busy vs model", 64'(fill_busy[b]), 64'(m_full[b][0] && m_full[b][1]));
        chk(sect_full[2*b] === m_full[b][0] && sect_full[2*b+1] === m_full[b][1], "R4/R6 sect_full vs model",
            64'(sect_full[2*b +: 2]), 64'({m_full[b][1], m_full[b][0]}));
        chk(rd_valid[b] === m_valid[b], "R7 rd_valid vs model", 64'(rd_valid[b]), 64'(m_valid[b]));
        chk(rd_data[b*DW +: DW] === m_data[b], "R3 rd_data vs model", rd_data[b*DW +: DW], m_data[b]);
      end
      for (int g = 0; g < NG; g++) begin
        bit e;
        e = 1;
        for (int k = 0; k < GS; k++) e = e && m_full[g*GS+k][m_r[g*GS+k]];
        chk(grp_ready[g] === e, "R8 grp_ready vs model", 64'(grp_ready[g]), 64'(e));
      end
    end
  end

  task automatic idle();
    mask_load = 0; wr_valid = 0; wr_last = 0; rd_req = '0; rd_release = '0;
  endtask

  task automatic load_mask(input logic [NB-1:0] m);
    @(negedge clk); idle(); mask_load = 1; mask_in = m;
    @(negedge clk); idle();
  endtask

  // broadcast one brick; optional mask load on last word; optional parallel reads on rd_bank
  task automatic send_brick(input int id, input bit load_last, input logic [NB-1:0] m,
                            input logic [NB-1:0] rd_bank);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      idle();
      wr_valid = 1; wr_addr = AW'(a); wr_data = wd(id, a); wr_last = (a == DEPTH-1);
      if (load_last && a == DEPTH-1) begin mask_load = 1; mask_in = m; end
      rd_req = rd_bank;
      for (int b = 0; b < NB; b++) rd_addr[b*AW +: AW] = AW'(a);
    end
    @(negedge clk); idle();
  endtask

  task automatic read_at(input logic [NB-1:0] banks, input int a);
    @(negedge clk); idle(); rd_req = banks;
    for (int b = 0; b < NB; b++) rd_addr[b*AW +: AW] = AW'(a);
    @(negedge clk); idle();
  endtask

  task automatic release_bank(input logic [NB-1:0] banks);
    @(negedge clk); idle(); rd_release = banks;
    @(negedge clk); idle();
  endtask

  initial begin
    rst_n = 0; idle(); mask_in = '0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(sect_full === '0, "R1 sect_full after reset", 64'(sect_full), 0);
    chk(fill_busy === '0, "R1 fill_busy after reset", 64'(fill_busy), 0);
    chk(rd_valid === '0, "R1 rd_valid after reset", 64'(rd_valid), 0);
    chk(rd_data === '0, "R1 rd_data after reset", rd_data[63:0], 0);
    chk(grp_ready === '0, "R1 grp_ready after reset", 64'(grp_ready), 0);
    cmp_on = 1;

    // R2: zero mask, and mask loaded together with the last word, capture nothing
    send_brick(1, 1, 4'b0101, 4'b0000);
    chk(sect_full === 8'h00, "R2 old mask used on load cycle", 64'(sect_full), 0);

    // R4: sparse mask fills banks 0 and 2 section 0
    send_brick(2, 0, '0, 4'b0000);
    chk(sect_full === 8'b0001_0001, "R4 sparse mask fill", 64'(sect_full), 64'h11);

    // R3 / R7: read filled and empty banks
    read_at(4'b0111, 3);
    chk(rd_valid === 4'b0101, "R7 read of empty bank invalid", 64'(rd_valid), 64'h5);
    chk(rd_data[0 +: DW] === wd(2, 3), "R3 bank0 word", rd_data[0 +: DW], wd(2, 3));
    chk(rd_data[2*DW +: DW] === rd_data[0 +: DW], "R3 copies identical", rd_data[2*DW +: DW], rd_data[0 +: DW]);

    // full mask: second section for banks 0/2, first for 1/3
    load_mask(4'b1111);
    send_brick(3, 0, '0, 4'b0000);
    chk(sect_full === 8'b0111_0111, "R4 alternate sections", 64'(sect_full), 64'h77);
    chk(fill_busy === 4'b0101, "R5 busy on both full", 64'(fill_busy), 64'h5);
    chk(grp_ready === 1'b1, "R8 group ready", 64'(grp_ready), 1);

    send_brick(4, 0, '0, 4'b0000);
    chk(sect_full === 8'hFF, "R5 banks 1/3 filled, 0/2 refused", 64'(sect_full), 64'hFF);
    send_brick(5, 0, '0, 4'b0000);
    chk(fill_busy === 4'b1111, "R5 all busy", 64'(fill_busy), 64'hF);

    // R5 contents unchanged, R6 release order
    read_at(4'b0011, 5);
    chk(rd_data[0 +: DW] === wd(2, 5), "R5 bank0 kept brick2", rd_data[0 +: DW], wd(2, 5));
    chk(rd_data[DW +: DW] === wd(3, 5), "R5 bank1 kept brick3", rd_data[DW +: DW], wd(3, 5));
    release_bank(4'b0001);
    chk(sect_full[1:0] === 2'b10, "R6 release clears section0", 64'(sect_full[1:0]), 2);
    read_at(4'b0001, 6);
    chk(rd_data[0 +: DW] === wd(3, 6), "R6 read moves to section1", rd_data[0 +: DW], wd(3, 6));

    // R9: fill bank0 section0 while reading bank0 section1
    load_mask(4'b0001);
    send_brick(6, 0, '0, 4'b0001);
    chk(sect_full[1:0] === 2'b11, "R9 fill during read", 64'(sect_full[1:0]), 3);

    // R6: release to empty, then release on empty has no effect
    release_bank(4'b0001);
    release_bank(4'b0001);
    chk(grp_ready === 1'b0, "R8 group not ready", 64'(grp_ready), 0);
    release_bank(4'b0001);
    chk(sect_full[1:0] === 2'b00, "R6 bank0 empty", 64'(sect_full[1:0]), 0);
    send_brick(7, 0, '0, 4'b0000);
    chk(sect_full[1:0] === 2'b10, "R4 fill resumes in section1", 64'(sect_full[1:0]), 2);
    read_at(4'b0001, 2);
    chk(rd_valid[0] === 1'b1, "R6 empty release kept read order", 64'(rd_valid[0]), 1);
    chk(rd_data[0 +: DW] === wd(7, 2), "R3 brick7 word", rd_data[0 +: DW], wd(7, 2));

    repeat (3) @(negedge clk);
    cmp_on = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1-flow act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule